// File: doc/BRIEF.md
# Redundant-Remainder Radix-2 Fraction Divider

This block divides one normalized fraction by another, one quotient digit per clock. Both operands arrive as unsigned values with a single integer bit and `W-1` fraction bits, with the integer bit set, so each lies in [1, 2). The partial remainder is held as a pair of bit vectors, one for the +1 digits and one for the -1 digits. Each step adds or subtracts the divisor digit by digit, with a transfer that moves at most one position, so no step waits on a carry chain.

A large divisor (above 1.5) causes both operands to be scaled by three quarters on entry. After every add or subtract, the top five remainder positions are folded into a canonical three-digit head. The next quotient digit is read from the single leading remainder digit, without any comparison against the divisor. Quotient digits in {-1, 0, +1} are turned into a plain binary quotient as they are produced, by keeping two candidate registers. No remainder correction is applied, so the result may differ from the true ratio by less than one unit in the last place.

Top module: `sd_radix2_divider`

## Requirements
- R1: While reset is held and after its release, `done` and `busy` are 0 and `quotient` is 0.
- R2: A `start` seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, `W` cycles after the start edge, and `busy` is low while `done` is high.
- R3: A `start` seen while `busy` is high has no effect: the running division finishes on its original schedule with the result for its original operands.
- R4: For a divisor no greater than 1.5 (binary 1.1), `quotient` is an unsigned value with one integer bit and `W-1` fraction bits. It differs from dividend/divisor by strictly less than 2^-(W-1).
- R5: For a divisor above 1.5, both operands are scaled by 0.75 before iterating, and the same bound as R4 holds on the unscaled ratio.
- R6: When dividend/divisor is an exact multiple of 2^-(W-1), `quotient` equals it exactly.
- R7: `quotient` changes only on the cycle `done` rises. It holds its value through the following idle and busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division with the present operands (ignored while busy) |
| dividend | input | W | Dividend, format 1.f, integer bit set |
| divisor | input | W | Divisor, format 1.f, integer bit set |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse with a new quotient |
| quotient | output | W | Binary quotient, format 1.f |

## Verification
The hardest situation to reach is a remainder whose folded head sits at the edge of the allowed range. That happens when a scaled divisor meets a remainder just above a quarter, and the step lands close to -1. No single directed pattern finds it reliably, so the bench sweeps every dividend against every divisor in a 7-bit configuration. That covers both sides of the scaling threshold and every exact-ratio case. Each result is checked against an integer error bound, and the head range is watched by an assertion. A second start, injected in the middle of a run, covers the ignore rule.

// File: rtl/sd_div_pkg.sv
package sd_div_pkg;
  // quotient digit chosen for one iteration
  typedef enum logic [1:0] {
    QD_ZERO = 2'b00,
    QD_POS  = 2'b01,
    QD_NEG  = 2'b10
  } qdigit_e;
endpackage

// File: rtl/sd_div_prescale.sv
// Operand entry: optional 3/4 scaling, remainder seeded at half the dividend
// so that the uniform step (double, then subtract) yields X - D first.
module sd_div_prescale #(
  parameter int W = 32
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   d,
  output logic [W+3:0]   rem0_p,
  output logic [W+3:0]   dv
);
  localparam int RW = W + 4;
  // divisor strictly above binary 1.1
  localparam logic [W-1:0] HALF_UP = {2'b11, {(W-2){1'b0}}};

  logic          scale;
  logic [RW-1:0] xe, de;

  always_comb begin
    scale  = (d > HALF_UP);
    xe     = RW'(x);
    de     = RW'(d);
    // remainder units are 2^-(W+2): X/2 = 4x, 0.75X/2 = 3x
    rem0_p = scale ? (xe + (xe << 1)) : (xe << 2);
    // D = 8d, 0.75D = 6d
    dv     = scale ? ((de << 1) + (de << 2)) : (de << 3);
  end
endmodule

// File: rtl/sd_div_step.sv
// One iteration: double the signed-digit remainder, add or subtract the
// divisor with a one-position transfer, then fold the head canonically.
module sd_div_step
  import sd_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W+3:0]      rp,
  input  logic [W+3:0]      rn,
  input  logic [W+3:0]      dv,
  input  qdigit_e           q,
  output logic [W+3:0]      np,
  output logic [W+3:0]      nn,
  output logic signed [5:0] fold_v
);
  localparam int RW = W + 4;

  logic [RW-1:0] sp, sn;
  int tr [RW+1];
  int wd [RW];
  int zd [RW];
  int v, m, sg;
  int h1, h2, h3;

  always_comb begin
    sp = {rp[RW-2:0], 1'b0};
    sn = {rn[RW-2:0], 1'b0};
    tr[0] = 0;
    for (int i = 0; i < RW; i++) begin
      int s, e;
      e = 0;
      if (q == QD_POS)      e = -int'(dv[i]);
      else if (q == QD_NEG) e =  int'(dv[i]);
      s = int'(sp[i]) - int'(sn[i]) + e;
      if (q == QD_NEG)      tr[i+1] = (s >= 1)  ? 1 : 0;
      else if (q == QD_POS) tr[i+1] = (s <= -1) ? -1 : 0;
      else                  tr[i+1] = 0;
      wd[i] = s - 2 * tr[i+1];
    end
    for (int i = 0; i < RW; i++) zd[i] = wd[i] + tr[i];

    // head value in quarters: weights 4, 2, 1, 1/2, 1/4
    v = 16 * tr[RW] + 8 * zd[RW-1] + 4 * zd[RW-2] + 2 * zd[RW-3] + zd[RW-4];
    fold_v = 6'(v);
    sg = (v < 0) ? -1 : 1;
    m  = (v < 0) ? -v : v;
    case (m)
      4:       begin h1 = 1; h2 =  0; h3 =  0; end
      3:       begin h1 = 1; h2 =  0; h3 = -1; end
      2:       begin h1 = 1; h2 = -1; h3 =  0; end
      1:       begin h1 = 0; h2 =  0; h3 =  1; end
      default: begin h1 = 0; h2 =  0; h3 =  0; end
    endcase
    zd[RW-1] = 0;
    zd[RW-2] = sg * h1;
    zd[RW-3] = sg * h2;
    zd[RW-4] = sg * h3;

    for (int i = 0; i < RW; i++) begin
      np[i] = (zd[i] > 0);
      nn[i] = (zd[i] < 0);
    end
  end
endmodule

// File: rtl/sd_div_otf.sv
// On-the-fly conversion: Q holds the quotient so far, T holds Q minus the
// weight of the last digit. Every update only sets one new low bit.
module sd_div_otf
  import sd_div_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          en,
  input  qdigit_e       q,
  input  logic [CW-1:0] k,
  output logic [W-1:0]  acc_next
);
  logic [W-1:0] acc_q, acc_t, t_next, bitw;

  always_comb begin
    bitw   = W'(1) << (W - 1 - int'(k));
    acc_next = acc_q;
    t_next   = acc_t;
    unique case (q)
      QD_POS: begin acc_next = acc_q | bitw; t_next = acc_q;        end
      QD_NEG: begin acc_next = acc_t | bitw; t_next = acc_t;        end
      default: begin acc_next = acc_q;       t_next = acc_t | bitw; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      acc_q <= '0;
      acc_t <= '0;
    end else if (en) begin
      acc_q <= acc_next;
      acc_t <= t_next;
    end
  end
endmodule

// File: rtl/sd_radix2_divider.sv
module sd_radix2_divider
  import sd_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int RW = W + 4;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [RW-1:0] rp, rn, dv;
  logic [RW-1:0] r0p, dvp, np, nn;
  logic [CW-1:0] cnt;
  logic signed [5:0] fold_v;
  logic [W-1:0]  acc_next;
  logic          accept;
  qdigit_e       qsel;

  assign accept = start && !busy;

  // digit selection: first step forced to +1, then leading digit (weight 1)
  always_comb begin
    if (cnt == '0)        qsel = QD_POS;
    else if (rp[RW-2])    qsel = QD_POS;
    else if (rn[RW-2])    qsel = QD_NEG;
    else                  qsel = QD_ZERO;
  end

  sd_div_prescale #(.W(W)) u_pre (
    .x(dividend), .d(divisor), .rem0_p(r0p), .dv(dvp)
  );

  sd_div_step #(.W(W)) u_step (
    .rp(rp), .rn(rn), .dv(dv), .q(qsel), .np(np), .nn(nn), .fold_v(fold_v)
  );

  sd_div_otf #(.W(W), .CW(CW)) u_otf (
    .clk(clk), .rst(rst), .init(accept), .en(busy), .q(qsel), .k(cnt),
    .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      rp       <= '0;
      rn       <= '0;
      dv       <= '0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
        rp   <= r0p;
        rn   <= '0;
        dv   <= dvp;
      end else if (busy) begin
        rp  <= np;
        rn  <= nn;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          quotient <= acc_next;
        end
      end
    end
  end

  // R2: done is a single-cycle pulse that follows the busy phase
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R3: a start during a run neither restarts nor stalls the counter
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
  // R4: folded head always fits the canonical three-digit range
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fold_v >= -6'sd4 && fold_v <= 6'sd4));
  // R4: the stored remainder never carries a digit above weight one
  p_head_clear_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!rp[RW-1] && !rn[RW-1]));
  // R7: the quotient only moves with done
  p_quo_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(quotient));
endmodule

// File: tb/sd_radix2_divider_bench.sv
module sd_radix2_divider_bench;
  localparam int W = 7;
  localparam int HALFW = 1 << (W - 1);
  localparam int LIMIT = 3 * (1 << (W - 2));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sd_radix2_divider #(.W(W)) u_sd_radix2_divider (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_div(input int xi, input int di, input bit inject);
    int lat;
    bit held;
    logic [W-1:0] prev;
    longint err;
    longint num;
    prev = quotient;
    held = 1'b1;
    @(negedge clk);
    dividend = W'(xi);
    divisor  = W'(di);
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (inject) check(busy == 1'b1, "R2 busy after start", busy, 1);
    lat = 0;
    while (1) begin
      if (inject && lat == 2) begin
        start = 1'b1;
        dividend = W'(HALFW + 5);
        divisor  = W'(2 * HALFW - 1);
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
      if (quotient != prev) held = 1'b0;
      if (lat > W + 5) break;
    end
    check(lat == W, inject ? "R3 latency with second start" : "R2 latency", lat, W);
    check(held, "R7 quotient held while busy", quotient, prev);
    check(!busy, "R2 busy low with done", busy, 0);
    num = longint'(xi) * HALFW;
    err = longint'(quotient) * di - num;
    if (inject)
      check(err > -di && err < di, "R3 result of first operands", quotient, num / di);
    else if (di <= LIMIT)
      check(err > -di && err < di, "R4 error bound", quotient, num / di);
    else
      check(err > -di && err < di, "R5 error bound scaled", quotient, num / di);
    if (num % di == 0)
      check(quotient == num / di, "R6 exact ratio", quotient, num / di);
    prev = quotient;
    @(negedge clk);
    check(!done, "R2 done one cycle", done, 0);
    check(quotient == prev, "R7 quotient held after done", quotient, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    check(!done && !busy, "R1 flags in reset", {done, busy}, 0);
    check(quotient == '0, "R1 quotient in reset", quotient, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !busy && quotient == '0, "R1 after release", quotient, 0);

    // R3: second start mid-run, below and above the scaling threshold
    run_div(HALFW + 17, HALFW + 3, 1'b1);
    run_div(2 * HALFW - 1, 2 * HALFW - 2, 1'b1);

    // R4 R5 R6: full sweep of both operands
    for (int xi = HALFW; xi < 2 * HALFW; xi++)
      for (int di = HALFW; di < 2 * HALFW; di++)
        run_div(xi, di, 1'b0);

    // R7: idle hold over several cycles
    begin
      logic [W-1:0] last;
      last = quotient;
      repeat (5) @(negedge clk);
      check(quotient == last && !done, "R7 idle hold", quotient, last);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule